// File: doc/BRIEF.md
# TAP State Navigator

This block drives a JTAG test access port from one parked controller state to another by generating a fixed TMS pattern, one bit per TCK period, while holding TDI low. Each command names an end state: Run-Test/Idle, Pause-IR, Pause-DR, Shift-IR or Shift-DR. It can also ask for a reset prefix, and it gives a number of extra TCK periods to spend in the end state with TMS low. The block keeps track of where it last parked the TAP. It picks the route from that tracked state, so the requester never has to work out TMS patterns.

The sequencer has three states. In WAIT it is idle, shows `cmd_ready` and accepts a command. In LOW, TCK is low and TMS is presented. In HIGH, TCK is high and the TAP samples TMS. The transitions are as follows. WAIT moves to LOW when it accepts a valid command. WAIT stays in WAIT when it rejects a command, and then pulses `done` together with `err`. LOW moves to HIGH when its half period ends. HIGH moves back to LOW when its half period ends and more bits remain. HIGH moves to WAIT when its half period ends on the last bit. On that last move it pulses `done` and updates the tracked state.

A route is built from up to three parts. The first is an optional reset prefix. The second is an exit from a shift state into the matching Pause state. The third is a route from Idle, or from a Pause state, to the target. After these come the idle-count zeros.

Top module: `tap_nav`

## Requirements
- R1: Reset state. While `rst_n` is low and right after it rises: `tck`=0, `tms`=0, `tdi`=0, `done`=0, `err`=0, `cmd_ready`=1, and `park_state`=7 (unknown). State codes are 0 Idle, 1 Pause-IR, 2 Pause-DR, 3 Shift-IR, 4 Shift-DR and 7 unknown.
- R2: When `cmd_reset`=1, the pattern starts with 10 TMS ones followed by one TMS zero. This brings any TAP to Run-Test/Idle. The rest of the route is then taken from Idle, whatever the tracked state.
- R3: From Idle, the routes are (LSB first in time): to Idle `0`; to Pause-IR `1,1,0,1,0`; to Pause-DR `1,0,1,0`; to Shift-IR `1,1,0,0`; to Shift-DR `1,0,0`.
- R4: From either Pause state, the routes are: to Idle `1,1,0`; to Pause-IR `1,1,1,1,0,1,0`; to Pause-DR `1,1,1,0,1,0`; to Shift-IR `1,1,1,1,0,0`; to Shift-DR `1,1,1,0,0`. The Shift routes are `1,1` to Update followed by the shift-entry path.
- R5: From a Shift state, the pattern first emits `1,0`. This gives Exit1 and then the matching Pause state. The Pause routes of R4 follow.
- R6: After the route, exactly `cmd_idles` further TCK periods are emitted with TMS 0.
- R7: On a successful command, `park_state` takes the target code in the same cycle that `done` pulses. It changes at no other time.
- R8: A command is rejected if its target code is above 4, or if the tracked state is not 0 to 4 and `cmd_reset`=0. On rejection, `done` and `err` pulse together one cycle after acceptance. No TCK rising edge occurs and `park_state` is unchanged.
- R9: Each TCK low half and each high half lasts `tck_half`+1 system clocks. A command of n bits therefore ends 2·(`tck_half`+1)·n clocks after acceptance. TMS never changes while TCK is high.
- R10: `tdi` is always 0.
- R11: `done` is a single-cycle pulse. `cmd_ready` is low while TCK periods are being generated and during the `done` cycle. TCK is low whenever `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck_half | input | HW | System clocks per TCK half period, minus one |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_target | input | 3 | Requested end state code |
| cmd_reset | input | 1 | Prefix the route with a TAP reset |
| cmd_idles | input | IW | Extra TCK periods with TMS low after the route |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command rejected (pulses with done) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in, held low |
| park_state | output | 3 | Tracked parked state code |

## Verification
The bench walks every origin (Idle, both Pause states, both Shift states) to every target. It captures TMS at each TCK rise and replays the bits through an independent sixteen-state TAP model. Landing in the wrong state exposes a wrong route, and a bit count that differs from the stated route length plus idle count exposes a padded or truncated pattern. Reset prefixes are placed into different origins, so a prefix that ignores the tracked state is told apart from one that depends on it. Three half-period settings separate a TCK divider error from a bit-count error. Rejected commands from the unknown state and with invalid targets show that nothing is clocked and the tracked state stays put.

// File: rtl/tap_nav_pkg.sv
package tap_nav_pkg;

    typedef enum logic [2:0] {
        TS_IDLE     = 3'd0,
        TS_PAUSE_IR = 3'd1,
        TS_PAUSE_DR = 3'd2,
        TS_SHIFT_IR = 3'd3,
        TS_SHIFT_DR = 3'd4,
        TS_UNKNOWN  = 3'd7
    } tap_loc_e;

    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } seq_e;

endpackage

// File: rtl/tap_nav_half.sv
module tap_nav_half #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] limit,
    output logic          half_end
);
    logic [HW-1:0] cnt;

    assign half_end = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || half_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit)); // R9

endmodule

// File: rtl/tap_nav_path.sv
module tap_nav_path import tap_nav_pkg::*; #(
    parameter int PW         = 20,
    parameter int LW         = 5,
    parameter int RESET_ONES = 10
) (
    input  logic [2:0]    origin,
    input  logic [2:0]    target,
    input  logic          with_reset,
    output logic [PW-1:0] bits,
    output logic [LW-1:0] len,
    output logic          bad
);
    // Route constants, bit 0 is emitted first.
    localparam logic [PW-1:0] RST_SEG = {{(PW-RESET_ONES){1'b0}}, {RESET_ONES{1'b1}}};

    logic [PW-1:0] pre, seg;
    logic [LW-1:0] pre_len, seg_len;
    logic          from_pause;

    always_comb begin
        pre        = '0;
        pre_len    = '0;
        from_pause = 1'b0;
        if (with_reset) begin
            pre     = RST_SEG;
            pre_len = LW'(RESET_ONES + 1);
        end else begin
            case (origin)
                TS_PAUSE_IR, TS_PAUSE_DR: from_pause = 1'b1;
                TS_SHIFT_IR, TS_SHIFT_DR: begin
                    pre        = PW'(1);      // 1 then 0: Exit1, Pause
                    pre_len    = LW'(2);
                    from_pause = 1'b1;
                end
                default: ;
            endcase
        end

        seg     = '0;
        seg_len = LW'(1);
        case ({from_pause, target})
            {1'b0, TS_IDLE}:     begin seg = PW'(7'b0000000); seg_len = LW'(1); end
            {1'b0, TS_PAUSE_IR}: begin seg = PW'(7'b0001011); seg_len = LW'(5); end
            {1'b0, TS_PAUSE_DR}: begin seg = PW'(7'b0000101); seg_len = LW'(4); end
            {1'b0, TS_SHIFT_IR}: begin seg = PW'(7'b0000011); seg_len = LW'(4); end
            {1'b0, TS_SHIFT_DR}: begin seg = PW'(7'b0000001); seg_len = LW'(3); end
            {1'b1, TS_IDLE}:     begin seg = PW'(7'b0000011); seg_len = LW'(3); end
            {1'b1, TS_PAUSE_IR}: begin seg = PW'(7'b0101111); seg_len = LW'(7); end
            {1'b1, TS_PAUSE_DR}: begin seg = PW'(7'b0010111); seg_len = LW'(6); end
            {1'b1, TS_SHIFT_IR}: begin seg = PW'(7'b0001111); seg_len = LW'(6); end
            {1'b1, TS_SHIFT_DR}: begin seg = PW'(7'b0000111); seg_len = LW'(5); end
            default: ;
        endcase

        bits = pre | (seg << pre_len);
        len  = pre_len + seg_len;
        bad  = (target > 3'd4) || (!with_reset && (origin > 3'd4));
    end

endmodule

// File: rtl/tap_nav.sv
module tap_nav import tap_nav_pkg::*; #(
    parameter int HW         = 8,
    parameter int IW         = 8,
    parameter int RESET_ONES = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] tck_half,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_target,
    input  logic          cmd_reset,
    input  logic [IW-1:0] cmd_idles,
    output logic          done,
    output logic          err,
    output logic          tck,
    output logic          tms,
    output logic          tdi,
    output logic [2:0]    park_state
);
    localparam int PW = RESET_ONES + 10;
    localparam int LW = $clog2(PW + 1);
    localparam int RW = ((LW > IW) ? LW : IW) + 1;

    seq_e          st, st_nx;
    tap_loc_e      park_q;
    logic          half_end, accept, pbad;
    logic [PW-1:0] pbits, pat;
    logic [LW-1:0] plen;
    logic [RW-1:0] remain;
    logic [2:0]    tgt_q;
    logic          tms_q, done_q, err_q;

    tap_nav_half #(.HW(HW)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st != S_WAIT),
        .limit    (tck_half),
        .half_end (half_end)
    );

    tap_nav_path #(.PW(PW), .LW(LW), .RESET_ONES(RESET_ONES)) u_path (
        .origin     (park_q),
        .target     (cmd_target),
        .with_reset (cmd_reset),
        .bits       (pbits),
        .len        (plen),
        .bad        (pbad)
    );

    assign cmd_ready  = (st == S_WAIT) && !done_q;
    assign accept     = cmd_valid && cmd_ready;
    assign tck        = (st == S_HIGH);
    assign tms        = tms_q;
    assign tdi        = 1'b0;
    assign done       = done_q;
    assign err        = err_q;
    assign park_state = park_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_WAIT: if (accept && !pbad) st_nx = S_LOW;
            S_LOW:  if (half_end) st_nx = S_HIGH;
            S_HIGH: if (half_end) st_nx = (remain == RW'(1)) ? S_WAIT : S_LOW;
            default: st_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_WAIT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            park_q <= TS_UNKNOWN;
            tms_q  <= 1'b0;
            pat    <= '0;
            remain <= '0;
            tgt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                if (pbad) begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end else begin
                    tms_q  <= pbits[0];
                    pat    <= pbits >> 1;
                    remain <= RW'(plen) + RW'(cmd_idles);
                    tgt_q  <= cmd_target;
                end
            end else if (st == S_HIGH && half_end) begin
                if (remain == RW'(1)) begin
                    done_q <= 1'b1;
                    park_q <= tap_loc_e'(tgt_q);
                    tms_q  <= 1'b0;
                end else begin
                    tms_q  <= pat[0];
                    pat    <= pat >> 1;
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    AST_TMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> $stable(tms)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_READY_NO_TCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tck); // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R8
    AST_PARK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(park_state) |-> (done && !err)); // R7

endmodule

// File: tb/tap_nav_bench.sv
`timescale 1ns/1ps
module tap_nav_bench;
    localparam int HW = 8;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] tck_half = 8'd1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_target = 3'd0;
    logic          cmd_reset = 1'b0;
    logic [IW-1:0] cmd_idles = '0;
    logic          done, err, tck, tms, tdi;
    logic [2:0]    park_state;

    always #10 clk = ~clk;

    tap_nav #(.HW(HW), .IW(IW), .RESET_ONES(10)) u_tap_nav (
        .clk(clk), .rst_n(rst_n), .tck_half(tck_half),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_target(cmd_target),
        .cmd_reset(cmd_reset), .cmd_idles(cmd_idles), .done(done), .err(err),
        .tck(tck), .tms(tms), .tdi(tdi), .park_state(park_state)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  cap [0:63];
    int  ncap = 0;
    int  hi_run = 0;
    int  hi_bad = 0;
    int  tdi_bad = 0;
    bit  tck_prev = 1'b0;
    int  cur = 7;      // tracked state as the bench expects it
    int  tap_s = 4;    // model TAP state, arbitrary before first reset

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: capture TMS at every TCK rise, measure high half lengths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tck && !tck_prev) begin
                if (ncap < 64) cap[ncap] = tms;
                ncap++;
            end
            if (tck) hi_run++;
            else if (tck_prev) begin
                if (hi_run != int'(tck_half) + 1) hi_bad++;
                hi_run = 0;
            end
            if (tdi !== 1'b0) tdi_bad++;
            tck_prev = tck;
        end
    end

    // Standard 16-state TAP controller model.
    function automatic int tap_next(input int s, input bit m);
        case (s)
            0:  return m ? 0  : 1;
            1:  return m ? 2  : 1;
            2:  return m ? 9  : 3;
            3:  return m ? 5  : 4;
            4:  return m ? 5  : 4;
            5:  return m ? 8  : 6;
            6:  return m ? 7  : 6;
            7:  return m ? 8  : 4;
            8:  return m ? 2  : 1;
            9:  return m ? 0  : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    function automatic int code_to_tap(input int c);
        case (c)
            0: return 1;
            1: return 13;
            2: return 6;
            3: return 11;
            default: return 4;
        endcase
    endfunction

    function automatic int route_len(input int o, input int t, input bit r);
        int n;
        bit pz;
        n  = r ? 11 : 0;
        pz = !r && (o != 0);
        if (!r && (o == 3 || o == 4)) n += 2;
        case (t)
            0: n += pz ? 3 : 1;
            1: n += pz ? 7 : 5;
            2: n += pz ? 6 : 4;
            3: n += pz ? 6 : 4;
            default: n += pz ? 5 : 3;
        endcase
        return n;
    endfunction

    task automatic run_cmd(input int t, input bit r, input int idl,
                           output int k, output bit e, output int rdy_bad);
        while (!cmd_ready) begin @(negedge clk); #1; end
        ncap = 0; hi_bad = 0; rdy_bad = 0;
        cmd_valid = 1'b1; cmd_target = 3'(t); cmd_reset = r; cmd_idles = IW'(idl);
        k = 0; e = 1'b0;
        forever begin
            @(negedge clk); #1;
            k++;
            if (k == 1) cmd_valid = 1'b0;
            if (done) begin e = err; break; end
            if (cmd_ready) rdy_bad++;
            if (k > 20000) break;
        end
    endtask

    task automatic do_nav(input int t, input bit r, input int idl);
        int k, rb, n, o, s;
        bit e;
        string tag;
        o = cur;
        n = route_len(o, t, r) + idl;
        if (r) tag = "R2";
        else if (o == 0) tag = "R3";
        else if (o == 1 || o == 2) tag = "R4";
        else tag = "R5";
        run_cmd(t, r, idl, k, e, rb);
        chk(e == 1'b0, "R8 no error on valid command", int'(e), 0);
        chk(ncap == n, {tag, " route bit count"}, ncap, n);
        s = tap_s;
        for (int i = 0; i < ncap && i < 64; i++) s = tap_next(s, cap[i]);
        chk(s == code_to_tap(t), {tag, " TAP lands on target"}, s, code_to_tap(t));
        if (r) begin
            int ones = 0;
            for (int i = 0; i < 10; i++) ones += int'(cap[i]);
            chk(ones == 10 && cap[10] == 1'b0, "R2 reset prefix 10 ones then 0", ones, 10);
        end
        if (idl > 0) begin
            int z = 0;
            for (int i = ncap - idl; i < ncap; i++) if (i >= 0 && cap[i] == 1'b0) z++;
            chk(z == idl, "R6 trailing TMS-low periods", z, idl);
        end
        chk(int'(park_state) == t, "R7 tracked state at done", int'(park_state), t);
        chk(k == 2 * (int'(tck_half) + 1) * n + 1, "R9 command duration", k,
            2 * (int'(tck_half) + 1) * n + 1);
        chk(hi_bad == 0, "R9 high half length", hi_bad, 0);
        chk(rb == 0, "R11 ready low while busy", rb, 0);
        @(negedge clk); #1;
        chk(!done && cmd_ready, "R11 done single pulse, ready back", int'(done), 0);
        cur   = t;
        tap_s = s;
    endtask

    task automatic bad_cmd(input int t, input bit r, input string what);
        int k, rb, p0;
        bit e;
        p0 = int'(park_state);
        run_cmd(t, r, 0, k, e, rb);
        chk(e == 1'b1 && k == 1, {"R8 reject ", what}, k, 1);
        chk(ncap == 0, {"R8 no TCK on reject ", what}, ncap, 0);
        chk(int'(park_state) == p0, {"R8 tracked unchanged ", what}, int'(park_state), p0);
        @(negedge clk); #1;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        #1;
        chk(tck == 0 && tms == 0 && tdi == 0, "R1 pins low in reset", {tck, tms, tdi}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(park_state == 3'd7, "R1 tracked unknown", int'(park_state), 7);
        chk(cmd_ready && !done && !err, "R1 ready, no done/err", {cmd_ready, done, err}, 4);

        bad_cmd(0, 1'b0, "from unknown");
        bad_cmd(5, 1'b1, "target 5");

        do_nav(0, 1'b1, 2);
        for (int o = 0; o < 5; o++) begin
            tck_half = (o == 3) ? 8'd2 : ((o == 4) ? 8'd0 : 8'd1);
            for (int t = 0; t < 5; t++) begin
                do_nav(o, 1'b0, (o + t) % 3);
                do_nav(t, ((o * 5 + t) % 7) == 3, t % 3);
            end
        end
        bad_cmd(6, 1'b0, "target 6");
        bad_cmd(7, 1'b0, "target 7");
        chk(tdi_bad == 0, "R10 tdi held low", tdi_bad, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule